// File: doc/BRIEF.md
# Serial port interrupt prioritiser

This block merges the five interrupt causes of a PC-style serial port into one identification value and one interrupt line. The causes are line error, receive timeout, receive data, transmit holding empty and modem status. Each cause has a pending flag. Surrounding logic raises a flag with a one-cycle set pulse and drops it with a clear pulse. The flags are masked by an interrupt enable register. The highest-priority cause that is both pending and enabled is encoded into the identification byte, and a registered interrupt output follows.

The block has two register ports. The enable port is written and read through a strobe and a data bus. The identification port is read through a strobe, and that read has a side effect on the transmit cause. A write strobe for the transmit holding register also clears the transmit cause. An output-gate control bit decides whether the interrupt line may be asserted at all. The FIFO enable and the transmit-queue-empty condition come in as levels from the surrounding serial port.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset every pending flag is clear, the enable readback is 0x00, the identification value is 0x01 and `irq` is 0.
- R2: When several enabled causes are pending, the one reported is chosen in this order, highest first: line error, receive timeout, receive data, transmit empty, modem status.
- R3: Identification bits [3:1] carry the cause code: 011 line error, 110 timeout, 010 receive data, 001 transmit empty, 000 modem status. Bit 0 is 1 only when no enabled cause is pending. Bits [5:4] read 0. Bits [7:6] read 11 while `fifo_on` is 1 and 00 otherwise.
- R4: An enable write stores only `ien_wdata[3:0]`, and `ien_rdata` returns them with bits [7:4] at 0. Bit 0 enables receive data, bit 1 transmit empty, bit 2 line error and bit 3 modem status.
- R5: The timeout cause is enabled only when the latest enable write had bit 0 set and `fifo_on` was 1 during that write.
- R6: An identification read (`iid_rd`) while transmit empty is the reported code clears the transmit-empty flag. A read while a different cause is reported leaves that flag unchanged.
- R7: An enable write with bit 1 set while `txq_empty` is 1 sets the transmit-empty flag. The same write with `txq_empty` at 0 does not set it.
- R8: A pulse on `thr_wr` clears the transmit-empty flag.
- R9: A set and a clear of the same cause in the same cycle leave the flag set.
- R10: `irq` is registered. It becomes 1 one cycle after an enabled cause becomes pending, and only while `out_gate` is 1. A cycle with `out_gate` at 0 gives `irq` at 0 in the next cycle.
- R11: A clear pulse on the error, timeout, receive or modem clear inputs drops that cause's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_on | input | 1 | FIFO mode level |
| txq_empty | input | 1 | Transmit queue empty level |
| out_gate | input | 1 | Output gate control bit for the interrupt line |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| ien_rdata | output | 8 | Enable register readback |
| iid_rd | input | 1 | Identification read strobe |
| iid_rdata | output | 8 | Identification value |
| thr_wr | input | 1 | Transmit holding write strobe (clears transmit cause) |
| err_set | input | 1 | Line error set pulse |
| tmo_set | input | 1 | Receive timeout set pulse |
| rxd_set | input | 1 | Receive data set pulse |
| txe_set | input | 1 | Transmit empty set pulse |
| msr_set | input | 1 | Modem status set pulse |
| err_clr | input | 1 | Line error clear pulse |
| tmo_clr | input | 1 | Receive timeout clear pulse |
| rxd_clr | input | 1 | Receive data clear pulse |
| msr_clr | input | 1 | Modem status clear pulse |
| irq | output | 1 | Registered interrupt line |

## Verification
The assertions check on every cycle that a set pulse always leaves its flag raised, that clear pulses and the read-side clear drop their flag when no set competes, and that enable writes store their low nibble. They also check that the timeout enable never comes on outside FIFO mode, that the line error code wins whenever line error is pending and enabled, and that the output gate holds `irq` low. The bench scenarios are needed to show the full priority order across mixed patterns of pending and enabled causes, and the FIFO marker bits. They also show the one-cycle `irq` latency, and that a read of a cause other than transmit empty leaves the transmit flag untouched.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC    = 5;
  localparam int SRC_ERR = 0;
  localparam int SRC_TMO = 1;
  localparam int SRC_RXD = 2;
  localparam int SRC_TXE = 3;
  localparam int SRC_MSR = 4;

  typedef logic [2:0] iid_code_t;

  // cause index (0 = highest priority) to identification code
  function automatic iid_code_t src_code(input int idx);
    case (idx)
      SRC_ERR: return 3'b011;
      SRC_TMO: return 3'b110;
      SRC_RXD: return 3'b010;
      SRC_TXE: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  // one-hot of the lowest set index
  function automatic logic [NSRC-1:0] first_set(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = NSRC'(1) << i;
    end
    return r;
  endfunction
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         pend_o[g] <= 1'b0;
      else if (set_i[g])  pend_o[g] <= 1'b1;
      else if (clr_i[g])  pend_o[g] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_o[g]); // R9

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]); // R11
  end
endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          fifo_on_i,
  input  logic          txq_empty_i,
  output logic [3:0]    ien_o,
  output logic          tmo_en_o,
  output logic          rearm_tx_o,
  output logic [DW-1:0] rdata_o
);
  localparam int HI_W = DW - 4;

  logic unused_hi;
  assign unused_hi = ^wdata_i[DW-1:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_o    <= 4'h0;
      tmo_en_o <= 1'b0;
    end else if (wr_i) begin
      ien_o    <= wdata_i[3:0];
      tmo_en_o <= wdata_i[0] & fifo_on_i;
    end
  end

  assign rearm_tx_o = wr_i & wdata_i[1] & txq_empty_i;
  assign rdata_o    = {{HI_W{1'b0}}, ien_o};

  AST_IEN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (rdata_o == {{HI_W{1'b0}}, $past(wdata_i[3:0])})); // R4

  AST_TMO_NEEDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !fifo_on_i) |=> !tmo_en_o); // R5
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
#(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] masked_i,
  input  logic            fifo_on_i,
  output logic [NSRC-1:0] grant_o,
  output logic            none_o,
  output logic [DW-1:0]   iid_o
);
  iid_code_t code;

  assign grant_o = first_set(masked_i);
  assign none_o  = ~|masked_i;

  always_comb begin
    code = 3'b000;
    for (int i = 0; i < NSRC; i++) begin
      if (grant_o[i]) code = src_code(i);
    end
  end

  assign iid_o = DW'({fifo_on_i ? 2'b11 : 2'b00, 2'b00, code, none_o});

  AST_ERR_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    masked_i[SRC_ERR] |-> (iid_o[3:1] == 3'b011)); // R2

  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (none_o == (grant_o == '0))); // R3
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_on,
  input  logic          txq_empty,
  input  logic          out_gate,
  input  logic          ien_wr,
  input  logic [DW-1:0] ien_wdata,
  output logic [DW-1:0] ien_rdata,
  input  logic          iid_rd,
  output logic [DW-1:0] iid_rdata,
  input  logic          thr_wr,
  input  logic          err_set,
  input  logic          tmo_set,
  input  logic          rxd_set,
  input  logic          txe_set,
  input  logic          msr_set,
  input  logic          err_clr,
  input  logic          tmo_clr,
  input  logic          rxd_clr,
  input  logic          msr_clr,
  output logic          irq
);
  logic [3:0]      ien_q;
  logic            tmo_en;
  logic            rearm_tx;
  logic [NSRC-1:0] src_set, src_clr, pend, en_vec, masked, grant;
  logic            none;
  logic            tx_read_clear;

  uart_irq_enable #(.DW(DW)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr_i(ien_wr), .wdata_i(ien_wdata),
    .fifo_on_i(fifo_on), .txq_empty_i(txq_empty), .ien_o(ien_q),
    .tmo_en_o(tmo_en), .rearm_tx_o(rearm_tx), .rdata_o(ien_rdata)
  );

  assign tx_read_clear = iid_rd & grant[SRC_TXE];

  always_comb begin
    src_set          = '0;
    src_set[SRC_ERR] = err_set;
    src_set[SRC_TMO] = tmo_set;
    src_set[SRC_RXD] = rxd_set;
    src_set[SRC_TXE] = txe_set | rearm_tx;
    src_set[SRC_MSR] = msr_set;
    src_clr          = '0;
    src_clr[SRC_ERR] = err_clr;
    src_clr[SRC_TMO] = tmo_clr;
    src_clr[SRC_RXD] = rxd_clr;
    src_clr[SRC_TXE] = thr_wr | tx_read_clear;
    src_clr[SRC_MSR] = msr_clr;
    en_vec           = '0;
    en_vec[SRC_ERR]  = ien_q[2];
    en_vec[SRC_TMO]  = tmo_en;
    en_vec[SRC_RXD]  = ien_q[0];
    en_vec[SRC_TXE]  = ien_q[1];
    en_vec[SRC_MSR]  = ien_q[3];
  end

  uart_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr), .pend_o(pend)
  );

  assign masked = pend & en_vec;

  uart_irq_encode #(.NSRC(NSRC), .DW(DW)) u_encode (
    .clk(clk), .rst_n(rst_n), .masked_i(masked), .fifo_on_i(fifo_on),
    .grant_o(grant), .none_o(none), .iid_o(iid_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= out_gate & ~none;
  end

  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !out_gate |=> !irq); // R10

  AST_TX_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_read_clear && !txe_set && !rearm_tx) |=> !pend[SRC_TXE]); // R6

  AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !txe_set && !rearm_tx) |=> !pend[SRC_TXE]); // R8

  AST_REARM_TX: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_tx |=> pend[SRC_TXE]); // R7
endmodule

// File: tb/uart_irq_prio_tb.sv
module uart_irq_prio_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_on = 1'b0, txq_empty = 1'b0, out_gate = 1'b0;
  logic       ien_wr = 1'b0, iid_rd = 1'b0, thr_wr = 1'b0;
  logic [7:0] ien_wdata = 8'h00;
  logic [7:0] ien_rdata, iid_rdata;
  logic       err_set = 0, tmo_set = 0, rxd_set = 0, txe_set = 0, msr_set = 0;
  logic       err_clr = 0, tmo_clr = 0, rxd_clr = 0, msr_clr = 0;
  logic       irq;
  int         checks = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  uart_irq_prio u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .txq_empty(txq_empty),
    .out_gate(out_gate), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .ien_rdata(ien_rdata), .iid_rd(iid_rd), .iid_rdata(iid_rdata),
    .thr_wr(thr_wr), .err_set(err_set), .tmo_set(tmo_set), .rxd_set(rxd_set),
    .txe_set(txe_set), .msr_set(msr_set), .err_clr(err_clr), .tmo_clr(tmo_clr),
    .rxd_clr(rxd_clr), .msr_clr(msr_clr), .irq(irq)
  );

  // vector: sets {msr,txe,rxd,tmo,err}, enable nibble, fifo, expected id
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {5'b11111, 4'b1111, 1'b1, 8'hC6},
    {5'b11110, 4'b1111, 1'b1, 8'hCC},
    {5'b11110, 4'b1111, 1'b0, 8'h04},
    {5'b11000, 4'b1111, 1'b0, 8'h02},
    {5'b10000, 4'b1111, 1'b0, 8'h00},
    {5'b11111, 4'b0000, 1'b0, 8'h01},
    {5'b00001, 4'b1011, 1'b1, 8'hC1},
    {5'b10101, 4'b1001, 1'b0, 8'h04}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic write_ien(input logic [7:0] v, input logic f);
    fifo_on = f; ien_wdata = v; ien_wr = 1'b1;
    @(negedge clk);
    ien_wr = 1'b0;
  endtask

  task automatic pulse_sets(input logic [4:0] s);
    {msr_set, txe_set, rxd_set, tmo_set, err_set} = s;
    @(negedge clk);
    {msr_set, txe_set, rxd_set, tmo_set, err_set} = 5'b0;
  endtask

  task automatic cleanup();
    write_ien(8'h00, 1'b0);
    {msr_clr, rxd_clr, tmo_clr, err_clr, thr_wr} = 5'b11111;
    @(negedge clk);
    {msr_clr, rxd_clr, tmo_clr, err_clr, thr_wr} = 5'b00000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 iid after reset", iid_rdata, 8'h01);
    check("R1 ien after reset", ien_rdata, 8'h00);
    check("R1 irq after reset", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      write_ien({4'b0, VEC[i][12:9]}, VEC[i][8]);
      pulse_sets(VEC[i][17:13]);
      check($sformatf("R2 R3 R5 vector %0d", i), iid_rdata, VEC[i][7:0]);
      cleanup();
    end

    // R4: upper bits dropped
    write_ien(8'hFF, 1'b0);
    check("R4 ien readback", ien_rdata, 8'h0F);
    cleanup();

    // R6: read while tx reported clears it
    write_ien(8'h02, 1'b0);
    pulse_sets(5'b01000);
    check("R6 tx reported", iid_rdata, 8'h02);
    iid_rd = 1'b1; @(negedge clk); iid_rd = 1'b0;
    check("R6 tx cleared by read", iid_rdata, 8'h01);
    cleanup();

    // R6: read while rx reported keeps tx
    write_ien(8'h03, 1'b0);
    pulse_sets(5'b01100);
    check("R6 rx over tx", iid_rdata, 8'h04);
    iid_rd = 1'b1; @(negedge clk); iid_rd = 1'b0;
    rxd_clr = 1'b1; @(negedge clk); rxd_clr = 1'b0;
    check("R6 tx kept after rx read", iid_rdata, 8'h02);
    cleanup();

    // R7: re-arm on enable write
    txq_empty = 1'b1;
    write_ien(8'h02, 1'b0);
    check("R7 rearm with empty queue", iid_rdata, 8'h02);
    txq_empty = 1'b0;
    cleanup();
    write_ien(8'h02, 1'b0);
    check("R7 no rearm with busy queue", iid_rdata, 8'h01);
    cleanup();

    // R8: holding write clears tx
    write_ien(8'h02, 1'b0);
    pulse_sets(5'b01000);
    thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0;
    check("R8 thr write clears tx", iid_rdata, 8'h01);
    cleanup();

    // R9: set wins over clear
    write_ien(8'h04, 1'b0);
    err_set = 1'b1; err_clr = 1'b1; @(negedge clk); err_set = 1'b0; err_clr = 1'b0;
    check("R9 err set wins", iid_rdata, 8'h06);
    cleanup();
    write_ien(8'h02, 1'b0);
    pulse_sets(5'b01000);
    txe_set = 1'b1; iid_rd = 1'b1; @(negedge clk); txe_set = 1'b0; iid_rd = 1'b0;
    check("R9 tx set wins over read clear", iid_rdata, 8'h02);
    cleanup();

    // R10: gating and latency
    out_gate = 1'b0;
    write_ien(8'h04, 1'b0);
    pulse_sets(5'b00001);
    @(negedge clk);
    check("R10 gated irq low", {7'b0, irq}, 8'h00);
    out_gate = 1'b1;
    @(negedge clk);
    check("R10 irq after gate on", {7'b0, irq}, 8'h01);
    cleanup();
    @(negedge clk);
    check("R10 irq low when idle", {7'b0, irq}, 8'h00);
    write_ien(8'h04, 1'b0);
    pulse_sets(5'b00001);
    check("R10 irq not yet high", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R10 irq one cycle later", {7'b0, irq}, 8'h01);

    // R11: clear pulses
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check("R11 err cleared", iid_rdata, 8'h01);
    write_ien(8'h09, 1'b1);
    pulse_sets(5'b10110);
    tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    check("R11 tmo cleared, rx shown", iid_rdata, 8'hC4);
    rxd_clr = 1'b1; @(negedge clk); rxd_clr = 1'b0;
    check("R11 rx cleared, modem shown", iid_rdata, 8'hC0);
    msr_clr = 1'b1; @(negedge clk); msr_clr = 1'b0;
    check("R11 modem cleared", iid_rdata, 8'hC1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule